// File: doc/BRIEF.md
# Holdover Frequency History Controller

This block sits between a digital PLL's loop filter and its numerically controlled oscillator, and it produces the oscillator's frequency control word. While the input is healthy, the block is in tracking mode. It passes the loop's live frequency word to its output. On every sample tick it also records that word into a history pipeline. The pipeline first delays each sample by a guard interval. It then averages the delayed samples over fixed-length blocks, and the most recently completed block average becomes the history value.

When a loss-of-signal flag is raised on the selected input, the block enters holdover and captures a target. The target is the history value, or the last tracked word if no averaging block has ever completed. The output is first frozen at the last tracked word for a fixed number of ticks. It then ramps toward the target in bounded steps and stops exactly on it. History accumulation is frozen for the whole of holdover. The block returns to tracking only when the input is free of loss of signal and is flagged as validated. On that return it raises a one-cycle request that a downstream phase buildout stage uses to absorb the phase step.

Top module: `holdover_freq_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the outputs are freq_o = 0, holdover_o = 0, ramp_done_o = 0 and buildout_req_o = 0.
- R2: In tracking mode, freq_o equals the value freq_i had at the previous rising clock edge.
- R3: A rising clock edge that sees los_i = 1 in tracking mode puts the block in holdover, and holdover_o = 1 from the next cycle on.
- R4: For the first FREEZE_TICKS sample ticks of holdover, freq_o holds the last value it had in tracking.
- R5: After the freeze, each sample tick moves freq_o toward the target by at most RAMP_STEP, without passing it. Between ticks freq_o does not change.
- R6: ramp_done_o is 1 exactly when the ramp phase is active and freq_o equals the target.
- R7: The target is the mean of the WIN_TICKS delayed samples in the most recently completed block. Samples reach a block only after GUARD_TICKS further tracking ticks have been recorded, so the most recent GUARD_TICKS samples never count.
- R8: If no averaging block has completed when holdover starts, the target is the last tracked value.
- R9: Holdover ends only on an edge that sees los_i = 0 and in_valid_i = 1. At that edge freq_o takes freq_i and buildout_req_o pulses for exactly one cycle.
- R10: Ticks during holdover, and a tick on the edge that starts holdover, are not recorded, so the history value stays unchanged across holdover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample tick, one cycle wide |
| freq_i | input | FW | Live frequency word from the loop filter |
| los_i | input | 1 | Loss of signal on the selected input |
| in_valid_i | input | 1 | Returned input has been validated |
| freq_o | output | FW | Frequency control word to the oscillator |
| holdover_o | output | 1 | Holdover in progress |
| ramp_done_o | output | 1 | Ramp has reached the target |
| buildout_req_o | output | 1 | One-cycle phase buildout request on return to tracking |

## Verification
The assertions assume that freq_i is an unsigned word and that in_valid_i is never high while los_i is high. They also assume that tick_i is a one-cycle pulse. The stimulus drives in_valid_i only in cycles where los_i is low. It changes inputs only on the falling clock edge, and it issues ticks as single-cycle random pulses. Random episodes vary the tracking length, the fault duration and the validation delay. Some faults fall before the first averaging block completes, and some holdovers follow each other with no new block in between.

// File: rtl/hfc_pkg.sv
package hfc_pkg;
    typedef enum logic [1:0] {
        ST_TRACK  = 2'd0,
        ST_FREEZE = 2'd1,
        ST_RAMP   = 2'd2
    } hfc_state_e;
endpackage

// File: rtl/hfc_guard_line.sv
module hfc_guard_line #(
    parameter int FW          = 16,
    parameter int GUARD_TICKS = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          en_i,
    input  logic [FW-1:0] din_i,
    output logic          fire_o,
    output logic [FW-1:0] dout_o
);
    localparam int CW = $clog2(GUARD_TICKS + 1);
    localparam logic [CW-1:0] FULL = CW'(GUARD_TICKS);

    typedef struct packed {
        logic [GUARD_TICKS-1:0][FW-1:0] stage;
        logic [CW-1:0]                  fill;
    } line_t;

    line_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (en_i) begin
            s_d.stage[0] = din_i;
            for (int i = 1; i < GUARD_TICKS; i++) begin
                s_d.stage[i] = s_q.stage[i-1];
            end
            if (s_q.fill != FULL) s_d.fill = s_q.fill + CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign fire_o = en_i && (s_q.fill == FULL);
    assign dout_o = s_q.stage[GUARD_TICKS-1];

    // R7
    fill_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.fill <= FULL);
    // R10
    line_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> $stable(s_q));
endmodule

// File: rtl/hfc_block_avg.sv
module hfc_block_avg #(
    parameter int FW       = 16,
    parameter int WIN_LOG2 = 3
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          en_i,
    input  logic [FW-1:0] din_i,
    output logic [FW-1:0] hist_o,
    output logic          hist_valid_o
);
    localparam int AW = FW + WIN_LOG2;
    localparam int CW = (WIN_LOG2 > 0) ? WIN_LOG2 : 1;
    localparam logic [CW-1:0] LAST = CW'((1 << WIN_LOG2) - 1);

    typedef struct packed {
        logic [AW-1:0] acc;
        logic [CW-1:0] cnt;
        logic [FW-1:0] hist;
        logic          hv;
    } avg_t;

    avg_t s_d, s_q;
    logic [AW-1:0] acc_sum;

    always_comb begin
        s_d     = s_q;
        acc_sum = s_q.acc + AW'(din_i);
        if (en_i) begin
            if (s_q.cnt == LAST) begin
                s_d.hist = FW'(acc_sum >> WIN_LOG2);
                s_d.hv   = 1'b1;
                s_d.acc  = '0;
                s_d.cnt  = '0;
            end else begin
                s_d.acc = acc_sum;
                s_d.cnt = s_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign hist_o       = s_q.hist;
    assign hist_valid_o = s_q.hv;

    // R10
    hist_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> ($stable(s_q.hist) && $stable(s_q.hv)));
    // R8
    hv_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.hv |=> s_q.hv);
endmodule

// File: rtl/hfc_ramp_step.sv
module hfc_ramp_step #(
    parameter int FW        = 16,
    parameter int RAMP_STEP = 16
) (
    input  logic [FW-1:0] cur_i,
    input  logic [FW-1:0] tgt_i,
    output logic [FW-1:0] nxt_o
);
    localparam logic [FW-1:0] STEP_W = FW'(RAMP_STEP);

    logic [FW-1:0] gap;

    always_comb begin
        if (tgt_i > cur_i) begin
            gap   = tgt_i - cur_i;
            nxt_o = (gap > STEP_W) ? cur_i + STEP_W : tgt_i;
        end else begin
            gap   = cur_i - tgt_i;
            nxt_o = (gap > STEP_W) ? cur_i - STEP_W : tgt_i;
        end
    end
endmodule

// File: rtl/holdover_freq_ctrl.sv
module holdover_freq_ctrl
    import hfc_pkg::*;
#(
    parameter int FW           = 16,
    parameter int WIN_LOG2     = 3,
    parameter int GUARD_TICKS  = 4,
    parameter int FREEZE_TICKS = 3,
    parameter int RAMP_STEP    = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic [FW-1:0] freq_i,
    input  logic          los_i,
    input  logic          in_valid_i,
    output logic [FW-1:0] freq_o,
    output logic          holdover_o,
    output logic          ramp_done_o,
    output logic          buildout_req_o
);
    localparam int CW = $clog2(FREEZE_TICKS + 1);
    localparam logic [CW-1:0] FRZ_LAST = CW'(FREEZE_TICKS - 1);
    localparam logic [FW-1:0] STEP_W   = FW'(RAMP_STEP);

    typedef struct packed {
        hfc_state_e    st;
        logic [FW-1:0] out;
        logic [FW-1:0] tgt;
        logic [CW-1:0] cnt;
        logic          bo;
    } ctrl_t;

    ctrl_t s_d, s_q;

    logic          rec_en, fire;
    logic [FW-1:0] delayed, hist;
    logic          hist_valid;
    logic [FW-1:0] ramp_nxt;
    logic          in_hold, leave;

    assign in_hold = (s_q.st != ST_TRACK);
    assign leave   = in_hold && !los_i && in_valid_i;
    assign rec_en  = tick_i && (s_q.st == ST_TRACK) && !los_i;

    hfc_guard_line #(.FW(FW), .GUARD_TICKS(GUARD_TICKS)) i_guard (
        .clk_i (clk_i), .rst_ni(rst_ni), .en_i(rec_en), .din_i(freq_i),
        .fire_o(fire), .dout_o(delayed)
    );

    hfc_block_avg #(.FW(FW), .WIN_LOG2(WIN_LOG2)) i_avg (
        .clk_i (clk_i), .rst_ni(rst_ni), .en_i(fire), .din_i(delayed),
        .hist_o(hist), .hist_valid_o(hist_valid)
    );

    hfc_ramp_step #(.FW(FW), .RAMP_STEP(RAMP_STEP)) i_step (
        .cur_i(s_q.out), .tgt_i(s_q.tgt), .nxt_o(ramp_nxt)
    );

    always_comb begin
        s_d    = s_q;
        s_d.bo = 1'b0;
        unique case (s_q.st)
            ST_TRACK: begin
                if (los_i) begin
                    s_d.st  = ST_FREEZE;
                    s_d.cnt = '0;
                    s_d.tgt = hist_valid ? hist : s_q.out;
                end else begin
                    s_d.out = freq_i;
                end
            end
            ST_FREEZE: begin
                if (tick_i) begin
                    if (s_q.cnt == FRZ_LAST) s_d.st = ST_RAMP;
                    else                     s_d.cnt = s_q.cnt + CW'(1);
                end
            end
            ST_RAMP: begin
                if (tick_i) s_d.out = ramp_nxt;
            end
            default: s_d.st = ST_TRACK;
        endcase
        if (leave) begin
            s_d.st  = ST_TRACK;
            s_d.out = freq_i;
            s_d.bo  = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{st: ST_TRACK, out: '0, tgt: '0, cnt: '0, bo: 1'b0};
        else         s_q <= s_d;
    end

    assign freq_o         = s_q.out;
    assign holdover_o     = in_hold;
    assign ramp_done_o    = (s_q.st == ST_RAMP) && (s_q.out == s_q.tgt);
    assign buildout_req_o = s_q.bo;

    function automatic logic [FW-1:0] absdiff(input logic [FW-1:0] a, input logic [FW-1:0] b);
        return (a > b) ? a - b : b - a;
    endfunction

    // R3
    los_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!in_hold && los_i) |=> holdover_o);
    // R4
    freeze_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.st == ST_FREEZE && !leave) |=> $stable(freq_o));
    // R5
    step_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.st == ST_RAMP && !leave) |=> absdiff(freq_o, $past(freq_o)) <= STEP_W);
    // R5
    no_overshoot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.st == ST_RAMP && !leave) |=>
            absdiff(freq_o, s_q.tgt) <= $past(absdiff(freq_o, s_q.tgt)));
    // R6
    done_stays_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ramp_done_o && !leave) |=> ramp_done_o);
    // R9
    bo_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        buildout_req_o |=> !buildout_req_o);
    // R9
    exit_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_hold && !(in_valid_i && !los_i)) |=> holdover_o);
    // R9
    bo_after_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(holdover_o) |-> buildout_req_o);
endmodule

// File: tb/test_holdover_freq_ctrl.sv
module test_holdover_freq_ctrl;
    localparam int FW = 16, WL = 3, W = 8, GUARD = 4, FRZ = 3, STEP = 16;

    logic clk = 1'b0, rst_ni = 1'b0, tick = 1'b0, los = 1'b0, vld = 1'b0;
    logic [FW-1:0] fin = '0;
    logic [FW-1:0] fout;
    logic hold, done, bo;

    always #5 clk = ~clk;

    holdover_freq_ctrl #(.FW(FW), .WIN_LOG2(WL), .GUARD_TICKS(GUARD),
                         .FREEZE_TICKS(FRZ), .RAMP_STEP(STEP)) i_holdover_freq_ctrl (
        .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .freq_i(fin), .los_i(los),
        .in_valid_i(vld), .freq_o(fout), .holdover_o(hold), .ramp_done_o(done),
        .buildout_req_o(bo)
    );

    int n_chk = 0, n_fail = 0;
    int samples [0:8191];
    int n_rec = 0;
    int m_st = 0, m_out = 0, m_tgt = 0, m_cnt = 0, m_bo = 0;
    int cyc = 0;

    function automatic int hist_of(input int n);
        int f, b, s;
        f = n - GUARD;
        if (f < W) return -1;
        b = f / W;
        s = 0;
        for (int i = 0; i < W; i++) s += samples[(b - 1) * W + i];
        return s / W;
    endfunction

    function automatic int stepped(input int cur, input int tgt);
        if (tgt > cur) return (tgt - cur > STEP) ? cur + STEP : tgt;
        return (cur - tgt > STEP) ? cur - STEP : tgt;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // reference model, advanced at every rising edge from the inputs held there
    always @(posedge clk) begin
        cyc++;
        if (!rst_ni) begin
            m_st = 0; m_out = 0; m_tgt = 0; m_cnt = 0; m_bo = 0; n_rec = 0;
        end else begin
            int h;
            m_bo = 0;
            if (m_st != 0 && !los && vld) begin
                m_st = 0; m_out = int'(fin); m_bo = 1;
            end else if (m_st == 0) begin
                if (los) begin
                    h = hist_of(n_rec);
                    m_tgt = (h < 0) ? m_out : h;
                    m_st = 1; m_cnt = 0;
                end else begin
                    m_out = int'(fin);
                    if (tick) begin samples[n_rec] = int'(fin); n_rec++; end
                end
            end else if (m_st == 1) begin
                if (tick) begin
                    if (m_cnt == FRZ - 1) m_st = 2; else m_cnt++;
                end
            end else if (tick) begin
                m_out = stepped(m_out, m_tgt);
            end
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (rst_ni) begin
            check(m_st == 0 ? "R2" : (m_st == 1 ? "R4" : "R5"), int'(fout), m_out);
            check("R3", int'(hold), (m_st != 0) ? 1 : 0);
            check("R6", int'(done), (m_st == 2 && m_out == m_tgt) ? 1 : 0);
            check("R9", int'(bo), m_bo);
        end
    end

    task automatic cycles(input int n, input int tick_pct);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = ($urandom % 100) < tick_pct;
            if (!los && !hold) fin = FW'(30000 + int'($urandom % 4000) - 2000);
        end
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic episode(input int track_len, input int fault_len, input int vwait);
        cycles(track_len, 50);
        los = 1'b1; vld = 1'b0;
        cycles(fault_len, 60);
        los = 1'b0;
        cycles(vwait, 60);
        vld = 1'b1;
        @(negedge clk); vld = 1'b0;
    endtask

    int saved_tgt;

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1
        check("R1", int'(fout), 0); check("R1", int'(hold), 0);
        check("R1", int'(done), 0); check("R1", int'(bo), 0);
        rst_ni = 1'b1;
        @(negedge clk);
        check("R1", int'(fout), 0); check("R1", int'(hold), 0);
        // R8: fault before any block completes; ramp target is last tracked word
        fin = 16'd31000;
        cycles(6, 50);
        los = 1'b1;
        @(negedge clk);
        saved_tgt = int'(fout);
        cycles(80, 100);
        check("R8", int'(fout), saved_tgt);
        check("R8", int'(done), 1);
        los = 1'b0; cycles(3, 0); vld = 1'b1; @(negedge clk); vld = 1'b0;
        check("R9", int'(bo), 1);
        @(negedge clk); check("R9", int'(bo), 0);
        // R7: long tracking, then a step just before the fault that must not count
        cycles(60, 100);
        fin = 16'd60000;
        for (int i = 0; i < 3; i++) begin @(negedge clk); tick = 1'b1; end
        @(negedge clk); tick = 1'b0;
        los = 1'b1;
        @(negedge clk);
        saved_tgt = hist_of(n_rec);
        cycles(2000, 100);
        check("R7", int'(fout), saved_tgt);
        los = 1'b0; vld = 1'b1; @(negedge clk); vld = 1'b0;
        // R10: immediate second fault with no new completed block keeps the target
        los = 1'b1;
        for (int i = 0; i < 5; i++) begin @(negedge clk); tick = 1'b1; end
        tick = 1'b0;
        cycles(2000, 100);
        check("R10", int'(fout), saved_tgt);
        los = 1'b0; vld = 1'b1; @(negedge clk); vld = 1'b0;
        // random episodes
        for (int e = 0; e < 25; e++)
            episode(int'($urandom % 80) + 2, int'($urandom % 300) + 1, int'($urandom % 6));
        cycles(20, 50);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule